// File: doc/BRIEF.md
# Four-Mode Rotating Register

A four-bit clocked register whose action on each rising clock edge is picked by a two-bit mode input. The four actions are keeping the stored value, taking a new value from the parallel data input, zeroing the stored value, and rotating the stored value one place toward the most significant bit. In a rotation the top bit wraps around into bit 0. The stored value is always visible on the output.

Each bit has its own flip-flop. A four-way selector feeds each flip-flop, and the mode drives every selector in the same way. The selector inputs are:

- the bit's own value,
- the matching data input bit,
- a constant zero,
- the bit one position below, which for bit 0 is the top bit.

An active-high asynchronous reset puts the register into a known zero state at start-up.

Top module: `rot4_reg`

## Requirements
- R1: While `rst_async` is 1, `dout` is 0000 without waiting for a clock edge.
- R2: Mode 2'b00 (keep) leaves `dout` unchanged at the clock edge, whatever `din` holds.
- R3: Mode 2'b01 (load) makes `dout` equal the `din` present at the clock edge.
- R4: Mode 2'b10 (zero) makes `dout` 0000 at the clock edge, whatever `din` holds.
- R5: Mode 2'b11 (rotate) makes the new `dout` {old[2], old[1], old[0], old[3]}, so 0101 becomes 1010 and 1000 becomes 0001. `din` is ignored.
- R6: A rotate never changes the number of 1 bits. Four rotates in a row give back the starting value.
- R7: `dout` changes only on a rising `clk` edge (or on reset). Changes to `mode` and `din` between edges have no effect until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_async | input | 1 | Asynchronous reset, active high, forces zero |
| mode | input | 2 | Action select: 00 keep, 01 load, 10 zero, 11 rotate left |
| din | input | 4 | Parallel data, bit 3 most significant |
| dout | output | 4 | Stored value |

## Verification
The bench goes after the wrap-around bit. If the wrap is wrong or missing, 1000 would rotate to 0000 rather than 0001, and a run of four rotates would not return to the start value. It puts a changing `din` under the keep, zero and rotate modes, because a decoder that leaks the load path would copy `din` into the register. It also changes `mode` and `din` mid-cycle and applies reset away from any edge. A design that is sensitive to levels, or whose reset is synchronous, would show those changes too early.

// File: rtl/rot4_reg_pkg.sv
package rot4_reg_pkg;
    localparam int REG_W = 4;

    typedef enum logic [1:0] {
        MODE_KEEP = 2'b00,
        MODE_LOAD = 2'b01,
        MODE_ZERO = 2'b10,
        MODE_ROTL = 2'b11
    } mode_e;

    typedef struct packed {
        logic [REG_W-1:0] val;
    } reg_state_t;
endpackage

// File: rtl/rot4_bit_sel.sv
module rot4_bit_sel
    import rot4_reg_pkg::*;
(
    input  mode_e mode,
    input  logic  own_q,
    input  logic  din_bit,
    input  logic  lower_q,
    output logic  nxt_d
);
    // Four-way choice for a single stored bit
    always_comb begin
        unique case (mode)
            MODE_KEEP: nxt_d = own_q;
            MODE_LOAD: nxt_d = din_bit;
            MODE_ZERO: nxt_d = 1'b0;
            MODE_ROTL: nxt_d = lower_q;
            default:   nxt_d = own_q;
        endcase
    end
endmodule

// File: rtl/rot4_reg.sv
module rot4_reg
    import rot4_reg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_async,
    input  logic [1:0]       mode,
    input  logic [REG_W-1:0] din,
    output logic [REG_W-1:0] dout
);
    localparam int TOP = REG_W - 1;

    mode_e            mode_sel;
    reg_state_t       state_d, state_q;
    logic [REG_W-1:0] bit_nxt;

    assign mode_sel = mode_e'(mode);

    // One selector per bit; bit 0 takes its rotate source from the top bit
    for (genvar gi = 0; gi < REG_W; gi++) begin : g_bit
        logic lower_src;
        if (gi == 0) begin : g_wrap
            assign lower_src = state_q.val[TOP];
        end else begin : g_chain
            assign lower_src = state_q.val[gi-1];
        end
        rot4_bit_sel u_sel (
            .mode    (mode_sel),
            .own_q   (state_q.val[gi]),
            .din_bit (din[gi]),
            .lower_q (lower_src),
            .nxt_d   (bit_nxt[gi])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.val = bit_nxt;
    end

    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async) state_q <= '0;
        else           state_q <= state_d;
    end

    assign dout = state_q.val;

    // R2
    keep_stable_chk: assert property (@(posedge clk) disable iff (rst_async)
        mode == 2'b00 |=> $stable(dout));
    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (rst_async)
        mode == 2'b01 |=> dout == $past(din));
    // R4
    zero_clear_chk: assert property (@(posedge clk) disable iff (rst_async)
        mode == 2'b10 |=> dout == '0);
    // R5
    rotl_wrap_chk: assert property (@(posedge clk) disable iff (rst_async)
        mode == 2'b11 |=> dout == {$past(dout[TOP-1:0]), $past(dout[TOP])});
    // R6
    rotl_ones_chk: assert property (@(posedge clk) disable iff (rst_async)
        mode == 2'b11 |=> $countones(dout) == $countones($past(dout)));
endmodule

// File: tb/sim_rot4_reg.sv
module sim_rot4_reg;
    logic       clk = 1'b0;
    logic       rst_async = 1'b1;
    logic [1:0] mode = 2'b00;
    logic [3:0] din = 4'h0;
    logic [3:0] dout;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rot4_reg u0 (.clk(clk), .rst_async(rst_async), .mode(mode), .din(din), .dout(dout));

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive at negedge, sample 2 ns after the following rising edge
    task automatic step(input logic [1:0] m, input logic [3:0] d);
        @(negedge clk);
        mode = m; din = d;
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        #3; chk("R1 reset level", dout, 4'b0000);
        step(2'b01, 4'b1011);
        chk("R1 reset holds through edge", dout, 4'b0000);
        @(negedge clk); rst_async = 1'b0;
    endtask

    task automatic t_load();
        step(2'b01, 4'b1011); chk("R3 load 1011", dout, 4'b1011);
        step(2'b01, 4'b0100); chk("R3 load 0100", dout, 4'b0100);
        step(2'b01, 4'b1111); chk("R3 load 1111", dout, 4'b1111);
    endtask

    task automatic t_keep();
        step(2'b01, 4'b0110);
        step(2'b00, 4'b1001); chk("R2 keep ignores din", dout, 4'b0110);
        step(2'b00, 4'b1111); chk("R2 keep second edge", dout, 4'b0110);
    endtask

    task automatic t_zero();
        step(2'b01, 4'b1101);
        step(2'b10, 4'b1111); chk("R4 zero ignores din", dout, 4'b0000);
        step(2'b10, 4'b0101); chk("R4 zero stays zero", dout, 4'b0000);
    endtask

    task automatic t_rotate();
        step(2'b01, 4'b0101);
        step(2'b11, 4'b1111); chk("R5 rotate 0101", dout, 4'b1010);
        step(2'b01, 4'b1000);
        step(2'b11, 4'b0000); chk("R5 rotate wrap 1000", dout, 4'b0001);
        step(2'b11, 4'b1111); chk("R5 rotate 0001", dout, 4'b0010);
    endtask

    task automatic t_cycle();
        step(2'b01, 4'b1100);
        for (int k = 0; k < 3; k++) step(2'b11, 4'b0011);
        chk("R6 three rotates", dout, 4'b0110);
        step(2'b11, 4'b0011);
        chk("R6 four rotates restore", dout, 4'b1100);
    endtask

    task automatic t_edge_only();
        step(2'b01, 4'b0011);
        @(negedge clk); mode = 2'b01; din = 4'b1110;
        #3; chk("R7 no change before edge", dout, 4'b0011);
        mode = 2'b10;
        #3; chk("R7 mode change mid-cycle", dout, 4'b0011);
        @(posedge clk); #2; chk("R7 action at edge", dout, 4'b0000);
    endtask

    task automatic t_async_reset();
        step(2'b01, 4'b1001);
        @(negedge clk); mode = 2'b00; #3;
        rst_async = 1'b1; #1;
        chk("R1 async reset mid-cycle", dout, 4'b0000);
        @(negedge clk); rst_async = 1'b0;
        step(2'b01, 4'b0111); chk("R3 load after reset", dout, 4'b0111);
    endtask

    initial begin
        t_reset();
        t_load();
        t_keep();
        t_zero();
        t_rotate();
        t_cycle();
        t_edge_only();
        t_async_reset();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule